// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Model

This block is a clock-synchronous, synthesizable stand-in for a byte-wide one-time-programmable read-only memory. It is meant for system simulations and emulation builds where the real part is not present. The model keeps its contents in a small register array. It decodes the part's three active-low control lines (select, output gate and program strobe) into read, standby, output-off, program, verify and inhibit behaviour.

Two level flags replace the high-voltage inputs. One marks the programming supply as raised. The other marks the identification voltage as present on the address line, and while it is set a fixed identification byte replaces array data on reads. The data bus is split into an input port, an output port and an output-enable, so the surrounding logic can build a tristate pad or a mux. A synchronous erase input returns the whole array to the blank state, which stands in for ultraviolet erasure.

Top module: `otp_rom_model`

## Requirements
- R1: After reset, or in the cycle after `erase_req` is sampled high, every location reads 0xFF. Erase takes priority over a write in the same cycle.
- R2: `dout_oe` is 1 only when `sel_n` and `gate_n` are both low and no program strobe is active. A program strobe is active when `vpp_hi` is 1 and `pgm_n` is 0. While `dout_oe` is 0, `dout` is 0x00.
- R3: With `sel_n` high the block is in standby: `dout_oe` is 0 whatever `gate_n` is, and program strobes leave the array unchanged.
- R4: A program pulse is `pgm_n` sampled low on one clock and sampled high on the next, with `vpp_hi`=1 and `sel_n`=0 on both clocks. On the clock where `pgm_n` is first sampled high, the byte at `addr` takes the value old AND `din`. The new value is visible on reads from the next cycle.
- R5: Programming only clears bits. A 1 in `din` leaves that bit as it was, and no sequence of writes turns a 0 back into a 1.
- R6: With `vpp_hi`=0, pulses on `pgm_n` have no effect on the array.
- R7: A verify read (`vpp_hi`=1, `sel_n`=0, `gate_n`=0, `pgm_n`=1) drives the stored byte exactly like a normal read.
- R8: While `id_hi`=1, a driven read returns 0x20 when `addr[0]`=0 and 0x61 when `addr[0]`=1, in place of array data. The array is not altered.
- R9: `proto_err` is 1 in the cycle after a clock that sampled `vpp_hi`=1 with `sel_n`, `gate_n` and `pgm_n` all low. Otherwise it is 0.
- R10: If `sel_n` rises while `pgm_n` is low, the following rise of `pgm_n` writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; blanks the array |
| erase_req | input | 1 | Synchronous blank request, all bytes to 0xFF |
| sel_n | input | 1 | Active-low device select |
| gate_n | input | 1 | Active-low output gate |
| pgm_n | input | 1 | Active-low program strobe |
| vpp_hi | input | 1 | Programming supply raised flag |
| id_hi | input | 1 | Identification voltage present flag |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data applied to the pins for programming |
| dout | output | 8 | Read data, 0x00 when not driving |
| dout_oe | output | 1 | Data pins driven by the block |
| proto_err | output | 1 | Gate and strobe were both low during programming |

## Verification
The bench targets the edge of the AND rule. Writing 0xFF over a programmed byte, and writing a pattern with extra 1s, must leave the stored zeros in place. A design that overwrote the byte would read back the raw input data. Strobes with the supply flag low, strobes with the device deselected, and a deselect in the middle of a strobe must all leave 0xFF behind. A missing inhibit shows up as a corrupted location. The bench also checks that the identification overlay follows the low address bit only and leaves the array intact, and that gate and strobe low together turn the outputs off at once while the error flag rises one cycle later. An off-by-one in either of those would mismatch the reference model on a specific clock.

// File: rtl/otp_rom_pkg.sv
// Package: shared constants and the control-mode type for the OTP memory model.
// Assumes an 8-bit data word; identification codes are fixed byte values.
package otp_rom_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam logic [BYTE_W-1:0] BLANK_BYTE = 8'hFF;
    localparam logic [BYTE_W-1:0] MFR_ID     = 8'h20;
    localparam logic [BYTE_W-1:0] DEV_ID     = 8'h61;

    typedef enum logic [2:0] {
        MODE_STANDBY,   // deselected, supply normal
        MODE_INHIBIT,   // deselected, supply raised
        MODE_OUTOFF,    // selected, gate high
        MODE_READ,      // selected, gate low, supply normal
        MODE_VERIFY,    // selected, gate low, supply raised, strobe high
        MODE_PROGRAM    // selected, supply raised, strobe low
    } otp_mode_e;
endpackage

// File: rtl/otp_ctrl.sv
// Module: otp_ctrl
// Decodes the control lines into a mode, detects completed program pulses
// and raises the protocol-error flag. Assumes all inputs are synchronous to clk.
module otp_ctrl
    import otp_rom_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sel_n,
    input  logic      gate_n,
    input  logic      pgm_n,
    input  logic      vpp_hi,
    output otp_mode_e mode,
    output logic      wr_en,
    output logic      proto_err
);
    logic armed_q;
    logic prog_ok;

    assign prog_ok = vpp_hi && !sel_n;

    // Mode decode from the current control levels.
    always_comb begin
        if (sel_n)                 mode = vpp_hi ? MODE_INHIBIT : MODE_STANDBY;
        else if (vpp_hi && !pgm_n) mode = MODE_PROGRAM;
        else if (gate_n)           mode = MODE_OUTOFF;
        else if (vpp_hi)           mode = MODE_VERIFY;
        else                       mode = MODE_READ;
    end

    // Remember a strobe-low sample taken under valid program conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= prog_ok && !pgm_n;
    end

    // A write completes when the strobe returns high with conditions still valid.
    assign wr_en = armed_q && pgm_n && prog_ok;

    // Flag gate and strobe low together while programming.
    always_ff @(posedge clk) begin
        if (!rst_n) proto_err <= 1'b0;
        else        proto_err <= prog_ok && !gate_n && !pgm_n;
    end

    // R10
    wr_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(!pgm_n && !sel_n && vpp_hi));

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(!gate_n && !pgm_n));
endmodule

// File: rtl/otp_array.sv
// Module: otp_array
// Register array of DEPTH bytes. Writes AND the new byte into the old one,
// erase or reset blanks every word. Assumes one write per clock at most.
module otp_array
    import otp_rom_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // Per-word storage: blank on reset/erase, clear-only update on write.
        always_ff @(posedge clk) begin
            if (!rst_n || erase)
                mem[g] <= BLANK_BYTE;
            else if (we && (waddr == ADDR_W'(g)))
                mem[g] <= mem[g] & wdata;
        end
    end

    // Asynchronous read port.
    assign rdata = mem[raddr];

    // R5
    bits_only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !erase) |=> ((mem[$past(waddr)] & ~$past(mem[waddr])) == '0));

    // R1
    erase_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (mem[0] == BLANK_BYTE && mem[DEPTH-1] == BLANK_BYTE));
endmodule

// File: rtl/otp_outmux.sv
// Module: otp_outmux
// Chooses between array data and the identification bytes and gates the
// data pins by mode. Assumes the mode already accounts for select and gate.
module otp_outmux
    import otp_rom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  otp_mode_e         mode,
    input  logic              id_hi,
    input  logic              addr_lsb,
    input  logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_oe
);
    logic [BYTE_W-1:0] sel_byte;

    // Identification overlay picked by the low address bit.
    always_comb begin
        if (id_hi) sel_byte = addr_lsb ? DEV_ID : MFR_ID;
        else       sel_byte = rdata;
    end

    // Drive only in the two read-type modes; zero otherwise.
    always_comb begin
        dout_oe = (mode == MODE_READ) || (mode == MODE_VERIFY);
        dout    = dout_oe ? sel_byte : '0;
    end

    // R8
    id_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && id_hi) |-> (dout == MFR_ID || dout == DEV_ID));
endmodule

// File: rtl/otp_rom_model.sv
// Module: otp_rom_model (top)
// Synthesizable behavioural model of a byte-wide one-time-programmable memory
// with select, gate and program strobe lines and high-voltage stand-in flags.
// Assumes all control inputs are synchronous to clk; the pads are built outside.
module otp_rom_model
    import otp_rom_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_req,
    input  logic              sel_n,
    input  logic              gate_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic              id_hi,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_oe,
    output logic              proto_err
);
    otp_mode_e         mode;
    logic              wr_en;
    logic [BYTE_W-1:0] rdata;

    otp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .gate_n    (gate_n),
        .pgm_n     (pgm_n),
        .vpp_hi    (vpp_hi),
        .mode      (mode),
        .wr_en     (wr_en),
        .proto_err (proto_err)
    );

    otp_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .erase (erase_req),
        .we    (wr_en),
        .waddr (addr),
        .wdata (din),
        .raddr (addr),
        .rdata (rdata)
    );

    otp_outmux u_outmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .id_hi    (id_hi),
        .addr_lsb (addr[0]),
        .rdata    (rdata),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

    // R2
    drive_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (!sel_n && !gate_n));

    // R3
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> (!dout_oe && dout == 8'h00));
endmodule

// File: tb/otp_rom_model_test.sv
`timescale 1ns/1ps
module otp_rom_model_test;
    localparam int AW = 6;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          erase_req = 1'b0;
    logic          sel_n = 1'b1;
    logic          gate_n = 1'b1;
    logic          pgm_n = 1'b1;
    logic          vpp_hi = 1'b0;
    logic          id_hi = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_oe;
    logic          proto_err;

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R1";

    // reference state
    logic [7:0] ref_mem [NW];
    bit         ref_low_seen = 0;
    bit         ref_err = 0;

    always #5 clk = ~clk;

    otp_rom_model #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .erase_req(erase_req), .sel_n(sel_n),
        .gate_n(gate_n), .pgm_n(pgm_n), .vpp_hi(vpp_hi), .id_hi(id_hi),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .proto_err(proto_err)
    );

    // Reference model: state advance on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (ref_mem[i]) ref_mem[i] = 8'hFF;
            ref_low_seen = 0;
            ref_err = 0;
        end else begin
            if (erase_req) foreach (ref_mem[i]) ref_mem[i] = 8'hFF;
            else if (ref_low_seen && pgm_n && vpp_hi && !sel_n)
                ref_mem[addr] = ref_mem[addr] & din;
            ref_low_seen = vpp_hi && !sel_n && !pgm_n;
            ref_err = vpp_hi && !sel_n && !gate_n && !pgm_n;
        end
    end

    function automatic bit exp_oe();
        return !sel_n && !gate_n && !(vpp_hi && !pgm_n);
    endfunction

    function automatic logic [7:0] exp_dout();
        if (!exp_oe()) return 8'h00;
        if (id_hi) return addr[0] ? 8'h61 : 8'h20;
        return ref_mem[addr];
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
        end
    endtask

    // Model comparison on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check({cur_req, " oe"},  {7'd0, dout_oe},   {7'd0, exp_oe()});
            check({cur_req, " data"}, dout, exp_dout());
            check({cur_req, " err"}, {7'd0, proto_err}, {7'd0, ref_err});
        end
    end

    task automatic nxt(int n = 1);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Direct read with a literal expectation, sampled mid-cycle.
    task automatic rd(logic [AW-1:0] a, logic [7:0] exp, bit vpp, string req);
        addr = a; sel_n = 0; gate_n = 0; pgm_n = 1; vpp_hi = vpp;
        @(negedge clk); #1;
        check(req, dout, exp);
        nxt();
    endtask

    // Program pulse: strobe low two clocks, then high one clock.
    task automatic pulse(logic [AW-1:0] a, logic [7:0] d, bit vpp, bit sel);
        addr = a; din = d; vpp_hi = vpp; sel_n = sel; gate_n = 1;
        pgm_n = 0; nxt(2);
        pgm_n = 1; nxt();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        nxt(3);
        rst_n = 1;
        cur_req = "R1";
        @(negedge clk); #1;
        check("R1 reset oe", {7'd0, dout_oe}, 8'd0);
        nxt();
        rd(0, 8'hFF, 0, "R1 blank first");
        rd(NW-1, 8'hFF, 0, "R1 blank last");

        cur_req = "R4";
        pulse(5, 8'hA5, 1, 0);
        cur_req = "R7";
        rd(5, 8'hA5, 1, "R7 verify after program");
        rd(5, 8'hA5, 0, "R4 normal read");

        cur_req = "R5";
        pulse(5, 8'h3C, 1, 0);
        rd(5, 8'h24, 0, "R5 and of old and new");
        pulse(5, 8'hFF, 1, 0);
        rd(5, 8'h24, 0, "R5 all ones no change");

        cur_req = "R6";
        pulse(6, 8'h00, 0, 0);
        rd(6, 8'hFF, 0, "R6 no supply no write");

        cur_req = "R3";
        sel_n = 1; gate_n = 0; vpp_hi = 0; addr = 5;
        @(negedge clk); #1;
        check("R3 standby oe", {7'd0, dout_oe}, 8'd0);
        check("R3 standby data", dout, 8'h00);
        nxt();
        pulse(7, 8'h00, 1, 1);
        rd(7, 8'hFF, 0, "R3 deselected strobe ignored");

        cur_req = "R10";
        addr = 8; din = 8'h00; vpp_hi = 1; sel_n = 0; gate_n = 1; pgm_n = 0;
        nxt(2);
        sel_n = 1; nxt();
        pgm_n = 1; nxt();
        sel_n = 0; nxt();
        rd(8, 8'hFF, 0, "R10 mid-pulse deselect inhibits");

        cur_req = "R8";
        id_hi = 1;
        rd(0, 8'h20, 0, "R8 manufacturer code");
        rd(1, 8'h61, 0, "R8 device code");
        rd(5, 8'h61, 0, "R8 odd address device code");
        rd(4, 8'h20, 1, "R8 code under verify");
        id_hi = 0;
        rd(5, 8'h24, 0, "R8 array unaltered");

        cur_req = "R9";
        addr = 9; din = 8'h0F; vpp_hi = 1; sel_n = 0; gate_n = 0; pgm_n = 0;
        @(negedge clk); #1;
        check("R9 outputs off in strobe", {7'd0, dout_oe}, 8'd0);
        nxt();
        @(negedge clk); #1;
        check("R9 error flag raised", {7'd0, proto_err}, 8'd1);
        pgm_n = 1; nxt(2);
        @(negedge clk); #1;
        check("R9 error flag clears", {7'd0, proto_err}, 8'd0);
        nxt();
        rd(9, 8'h0F, 0, "R9 byte still programmed");

        cur_req = "R2";
        sel_n = 0; gate_n = 1; vpp_hi = 0;
        @(negedge clk); #1;
        check("R2 gate high no drive", {7'd0, dout_oe}, 8'd0);
        check("R2 gate high zero data", dout, 8'h00);
        nxt();

        cur_req = "R1";
        erase_req = 1; nxt(); erase_req = 0;
        rd(5, 8'hFF, 0, "R1 erase blanks 5");
        rd(9, 8'hFF, 0, "R1 erase blanks 9");

        cur_req = "R5";
        for (int k = 0; k < 60; k++) begin
            automatic int op = int'($urandom_range(0, 3));
            if (op == 0)
                pulse(AW'($urandom), 8'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0));
            else begin
                addr = AW'($urandom); sel_n = 1'($urandom_range(0, 4) == 0);
                gate_n = 1'($urandom_range(0, 4) == 0); pgm_n = 1'($urandom_range(0, 4) != 0);
                vpp_hi = 1'($urandom); id_hi = 1'($urandom_range(0, 5) == 0);
                din = 8'($urandom);
                nxt();
                pgm_n = 1; id_hi = 0;
                nxt();
            end
        end

        nxt(2);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule